// File: doc/BRIEF.md
# Buddy Block Allocator

This block hands out pieces of a fixed memory region. It does not store any data itself; it only keeps track of which parts of the region are free. Every piece is a power-of-two number of units, aligned to its own size, with an order between `MIN_ORD` and `MAX_ORD`. The region is made of `TOP_BLOCKS` blocks of the largest order. Free state is kept as one bitmap per order.

An allocation request carries a size. The block turns the size into the smallest order that fits it. It then takes a free block of that order if one exists. If not, it takes a larger free block and halves it, one order per cycle, until a block of the needed order is left. Each upper half that is not used stays free. A release request carries an address and an order. The block frees that block and then joins it with its buddy, one order per cycle, for as long as the buddy is also free.

Only one operation is in progress at a time. Requests and responses each use a valid/ready handshake, and `busy` is high from the moment a request is accepted until its response is taken.

Top module: `buddy_alloc`

## Requirements
- R1: After reset, the whole region is free as `TOP_BLOCKS` blocks of order `MAX_ORD`. At that point `req_ready` is 1, `busy` is 0 and `rsp_valid` is 0.
- R2: An allocation of `req_size` units uses the smallest order k in [MIN_ORD, MAX_ORD] with 2^k >= size. A size of 0 uses `MIN_ORD`. A size above 2^MAX_ORD is answered with `rsp_fail`=1.
- R3: When a free block of order k exists, the grant is the free block of that order with the lowest address. It is reported as `rsp_addr` (in units, a multiple of 2^k) and `rsp_order`=k.
- R4: When no free block of order k exists, the lowest-addressed free block of the smallest larger order that has one is halved again and again. The lower half is kept each time, and every upper half becomes free at its own order.
- R5: When no free block of order k or above exists, the response has `rsp_fail`=1 and the free state is left unchanged.
- R6: A release frees the block. While the order is below `MAX_ORD` and the buddy (address XOR 2^order) is free at the same order, the two are joined into one block of the next order.
- R7: Releasing a block whose own bit at that order is already free gives `rsp_err`=1 and changes nothing.
- R8: A release with an order outside [MIN_ORD, MAX_ORD], or with an address that is not a multiple of 2^order, gives `rsp_err`=1 and changes nothing.
- R9: A request is taken when `req_valid` and `req_ready` are both high. From then until the response is taken, `req_ready` is low and `busy` is high. A response is held stable while `rsp_valid` is high and `rsp_ready` is low.
- R10: A successful release echoes its address and order, with `rsp_fail`=0 and `rsp_err`=0. `rsp_fail` is only ever set for allocations, and `rsp_err` only for releases.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 1 | Request present |
| req_ready | output | 1 | Block can take a request |
| req_release | input | 1 | 1 = release, 0 = allocate |
| req_size | input | MAX_ORD+2 | Units wanted (allocate) |
| req_addr | input | AW | Block address in units (release) |
| req_order | input | OW | Block order (release) |
| busy | output | 1 | An operation is in progress |
| rsp_valid | output | 1 | Response present |
| rsp_ready | input | 1 | Response taken |
| rsp_addr | output | AW | Granted or echoed address |
| rsp_order | output | OW | Granted or echoed order |
| rsp_fail | output | 1 | Allocation could not be served |
| rsp_err | output | 1 | Release rejected |

## Verification
A bad bitmap bit does not show up when it goes wrong. It shows up at the ports only when a later grant, failure or join depends on it. That can be many operations later: a block granted twice, a merge that never happens, or a wrong fail. For this reason the bench keeps its own model of the free state and checks every response against it, across long mixed sequences. A block that is missing from the map is exposed by the final drain-and-refill step, where full-size allocations must succeed again. Handshake faults show up within one cycle of acceptance or of a held response.

// File: rtl/buddy_pkg.sv
package buddy_pkg;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_SCAN,
    ST_SPLIT,
    ST_MERGE,
    ST_DONE
  } buddy_state_e;

  // Position of the first bit of order `ord` in the flat free map.
  // The orders are packed from smallest to largest.
  function automatic int unsigned order_base(int unsigned ord, int unsigned lo,
                                             int unsigned hi, int unsigned top);
    int unsigned acc;
    acc = 0;
    for (int unsigned o = lo; o <= hi; o++) begin
      if (o < ord) acc += top << (hi - o);
    end
    return acc;
  endfunction

endpackage

// File: rtl/buddy_order_calc.sv
module buddy_order_calc #(
  parameter int unsigned MIN_ORD = 5,
  parameter int unsigned MAX_ORD = 10,
  parameter int unsigned SW      = MAX_ORD + 2,
  parameter int unsigned OW      = $clog2(MAX_ORD + 1)
) (
  input  logic [SW-1:0] size,
  output logic [OW-1:0] ord,
  output logic          too_big
);
  // Smallest order whose block holds `size` units.
  // The loop runs downward, so the last match is the smallest order.
  always_comb begin
    ord     = OW'(MAX_ORD);
    too_big = (size > SW'(1 << MAX_ORD));
    for (int o = MAX_ORD; o >= int'(MIN_ORD); o--) begin
      if (size <= SW'(1 << o)) ord = OW'(o);
    end
  end
endmodule

// File: rtl/buddy_find_first.sv
module buddy_find_first #(
  parameter int unsigned W  = 8,
  parameter int unsigned IW = 3
) (
  input  logic [W-1:0]  bits,
  output logic          found,
  output logic [IW-1:0] idx
);
  // The lowest set bit wins.
  always_comb begin
    found = 1'b0;
    idx   = '0;
    for (int i = W - 1; i >= 0; i--) begin
      if (bits[i]) begin
        found = 1'b1;
        idx   = IW'(i);
      end
    end
  end
endmodule

// File: rtl/buddy_free_map.sv
module buddy_free_map #(
  parameter int unsigned TOP_BLOCKS = 2,
  parameter int unsigned TOT        = 126,
  parameter int unsigned FW         = 7
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic           clr_en,
  input  logic [FW-1:0]  clr_idx,
  input  logic           set_en,
  input  logic [FW-1:0]  set_idx,
  output logic [TOT-1:0] bits
);
  // The largest order sits at the top of the flat map.
  localparam logic [TOT-1:0] RST_MAP = {{TOP_BLOCKS{1'b1}}, {(TOT - TOP_BLOCKS){1'b0}}};

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      bits <= RST_MAP;
    end else begin
      if (clr_en) bits[clr_idx] <= 1'b0;
      if (set_en) bits[set_idx] <= 1'b1;
    end
  end
endmodule

// File: rtl/buddy_alloc.sv
module buddy_alloc #(
  parameter int unsigned MIN_ORD    = 5,
  parameter int unsigned MAX_ORD    = 10,
  parameter int unsigned TOP_BLOCKS = 2,
  localparam int unsigned TOPW      = (TOP_BLOCKS > 1) ? $clog2(TOP_BLOCKS) : 0,
  localparam int unsigned AW        = MAX_ORD + TOPW,
  localparam int unsigned SW        = MAX_ORD + 2,
  localparam int unsigned OW        = $clog2(MAX_ORD + 1)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          req_valid,
  output logic          req_ready,
  input  logic          req_release,
  input  logic [SW-1:0] req_size,
  input  logic [AW-1:0] req_addr,
  input  logic [OW-1:0] req_order,
  output logic          busy,
  output logic          rsp_valid,
  input  logic          rsp_ready,
  output logic [AW-1:0] rsp_addr,
  output logic [OW-1:0] rsp_order,
  output logic          rsp_fail,
  output logic          rsp_err
);
  import buddy_pkg::*;

  localparam int unsigned NORD = MAX_ORD - MIN_ORD + 1;
  localparam int unsigned IDXW = AW - MIN_ORD;
  localparam int unsigned TOT  = order_base(MAX_ORD + 1, MIN_ORD, MAX_ORD, TOP_BLOCKS);
  localparam int unsigned FW   = $clog2(TOT);

  function automatic logic [FW-1:0] fidx(logic [OW-1:0] o, logic [IDXW-1:0] i);
    return FW'(order_base(int'(o), MIN_ORD, MAX_ORD, TOP_BLOCKS) + int'(i));
  endfunction

  buddy_state_e  state, state_n;
  logic [OW-1:0] cur_ord, cur_ord_n, tgt_ord, tgt_ord_n;
  logic [IDXW-1:0] cur_idx, cur_idx_n;
  logic          op_release, op_release_n;
  logic [AW-1:0] rsp_addr_n;
  logic [OW-1:0] rsp_order_n;
  logic          rsp_fail_n, rsp_err_n;

  // Named internal events, used by the checker.
  logic          evt_grant, evt_split, evt_merge;

  logic           clr_en, set_en;
  logic [FW-1:0]  clr_idx, set_idx;
  logic [TOT-1:0] free_bits;

  buddy_free_map #(.TOP_BLOCKS(TOP_BLOCKS), .TOT(TOT), .FW(FW)) map_i (
    .clk(clk), .rst_n(rst_n),
    .clr_en(clr_en), .clr_idx(clr_idx),
    .set_en(set_en), .set_idx(set_idx),
    .bits(free_bits)
  );

  logic [OW-1:0] fit_ord;
  logic          fit_too_big;

  buddy_order_calc #(.MIN_ORD(MIN_ORD), .MAX_ORD(MAX_ORD), .SW(SW), .OW(OW)) calc_i (
    .size(req_size), .ord(fit_ord), .too_big(fit_too_big)
  );

  // One lowest-free-block finder per order.
  logic            found_v [NORD];
  logic [IDXW-1:0] idx_v   [NORD];

  for (genvar g = 0; g < NORD; g++) begin : g_ord
    localparam int unsigned ORD  = MIN_ORD + g;
    localparam int unsigned CNT  = TOP_BLOCKS << (MAX_ORD - ORD);
    localparam int unsigned BASE = order_base(ORD, MIN_ORD, MAX_ORD, TOP_BLOCKS);
    buddy_find_first #(.W(CNT), .IW(IDXW)) ff_i (
      .bits(free_bits[BASE+CNT-1:BASE]),
      .found(found_v[g]),
      .idx(idx_v[g])
    );
  end

  logic            sel_found;
  logic [IDXW-1:0] sel_idx;

  always_comb begin
    sel_found = 1'b0;
    sel_idx   = '0;
    for (int g = 0; g < int'(NORD); g++) begin
      if (int'(cur_ord) == int'(MIN_ORD) + g) begin
        sel_found = found_v[g];
        sel_idx   = idx_v[g];
      end
    end
  end

  // Checks on a release request, worked out while the block is idle.
  logic            rel_ord_ok, rel_aligned, rel_ok;
  logic [IDXW-1:0] rel_idx;
  logic [AW-1:0]   rel_mask;

  always_comb begin
    rel_ord_ok  = (req_order >= OW'(MIN_ORD)) && (req_order <= OW'(MAX_ORD));
    rel_mask    = (AW'(1) << req_order) - AW'(1);
    rel_aligned = ((req_addr & rel_mask) == '0);
    rel_idx     = IDXW'(req_addr >> req_order);
    rel_ok      = rel_ord_ok && rel_aligned && !free_bits[fidx(req_order, rel_idx)];
  end

  logic buddy_free;
  assign buddy_free = free_bits[fidx(cur_ord, cur_idx ^ IDXW'(1))];

  always_comb begin
    state_n      = state;
    cur_ord_n    = cur_ord;
    tgt_ord_n    = tgt_ord;
    cur_idx_n    = cur_idx;
    op_release_n = op_release;
    rsp_addr_n   = rsp_addr;
    rsp_order_n  = rsp_order;
    rsp_fail_n   = rsp_fail;
    rsp_err_n    = rsp_err;
    clr_en = 1'b0; clr_idx = '0;
    set_en = 1'b0; set_idx = '0;
    evt_grant = 1'b0; evt_split = 1'b0; evt_merge = 1'b0;

    unique case (state)
      ST_IDLE: begin
        if (req_valid) begin
          op_release_n = req_release;
          rsp_fail_n   = 1'b0;
          rsp_err_n    = 1'b0;
          if (req_release) begin
            rsp_addr_n  = req_addr;
            rsp_order_n = req_order;
            if (!rel_ok) begin
              rsp_err_n = 1'b1;
              state_n   = ST_DONE;
            end else begin
              cur_ord_n = req_order;
              cur_idx_n = rel_idx;
              state_n   = ST_MERGE;
            end
          end else if (fit_too_big) begin
            rsp_fail_n  = 1'b1;
            rsp_addr_n  = '0;
            rsp_order_n = '0;
            state_n     = ST_DONE;
          end else begin
            tgt_ord_n = fit_ord;
            cur_ord_n = fit_ord;
            state_n   = ST_SCAN;
          end
        end
      end

      ST_SCAN: begin
        if (sel_found) begin
          clr_en  = 1'b1;
          clr_idx = fidx(cur_ord, sel_idx);
          if (cur_ord == tgt_ord) begin
            cur_idx_n = sel_idx;
            evt_grant = 1'b1;
          end else begin
            evt_split = 1'b1;
            set_en    = 1'b1;
            set_idx   = fidx(cur_ord - OW'(1), (sel_idx << 1) | IDXW'(1));
            cur_ord_n = cur_ord - OW'(1);
            cur_idx_n = sel_idx << 1;
            evt_grant = (cur_ord - OW'(1) == tgt_ord);
          end
          state_n = evt_grant ? ST_DONE : ST_SPLIT;
        end else if (cur_ord == OW'(MAX_ORD)) begin
          rsp_fail_n  = 1'b1;
          rsp_addr_n  = '0;
          rsp_order_n = '0;
          state_n     = ST_DONE;
        end else begin
          cur_ord_n = cur_ord + OW'(1);
        end
      end

      ST_SPLIT: begin
        evt_split = 1'b1;
        set_en    = 1'b1;
        set_idx   = fidx(cur_ord - OW'(1), (cur_idx << 1) | IDXW'(1));
        cur_ord_n = cur_ord - OW'(1);
        cur_idx_n = cur_idx << 1;
        evt_grant = (cur_ord - OW'(1) == tgt_ord);
        if (evt_grant) state_n = ST_DONE;
      end

      ST_MERGE: begin
        if (cur_ord < OW'(MAX_ORD) && buddy_free) begin
          evt_merge = 1'b1;
          clr_en    = 1'b1;
          clr_idx   = fidx(cur_ord, cur_idx ^ IDXW'(1));
          cur_ord_n = cur_ord + OW'(1);
          cur_idx_n = cur_idx >> 1;
        end else begin
          set_en  = 1'b1;
          set_idx = fidx(cur_ord, cur_idx);
          state_n = ST_DONE;
        end
      end

      ST_DONE: begin
        if (rsp_ready) state_n = ST_IDLE;
      end

      default: state_n = ST_IDLE;
    endcase

    if (evt_grant) begin
      rsp_addr_n  = AW'(cur_idx_n) << cur_ord_n;
      rsp_order_n = cur_ord_n;
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state      <= ST_IDLE;
      cur_ord    <= '0;
      tgt_ord    <= '0;
      cur_idx    <= '0;
      op_release <= 1'b0;
      rsp_addr   <= '0;
      rsp_order  <= '0;
      rsp_fail   <= 1'b0;
      rsp_err    <= 1'b0;
    end else begin
      state      <= state_n;
      cur_ord    <= cur_ord_n;
      tgt_ord    <= tgt_ord_n;
      cur_idx    <= cur_idx_n;
      op_release <= op_release_n;
      rsp_addr   <= rsp_addr_n;
      rsp_order  <= rsp_order_n;
      rsp_fail   <= rsp_fail_n;
      rsp_err    <= rsp_err_n;
    end
  end

  assign req_ready = (state == ST_IDLE);
  assign rsp_valid = (state == ST_DONE);
  assign busy      = (state != ST_IDLE);

endmodule

// File: rtl/buddy_alloc_chk.sv
module buddy_alloc_chk #(
  parameter int unsigned MIN_ORD = 5,
  parameter int unsigned MAX_ORD = 10,
  parameter int unsigned AW      = 11,
  parameter int unsigned OW      = 4
) (
  input logic          clk,
  input logic          rst_n,
  input logic          req_ready,
  input logic          rsp_valid,
  input logic          rsp_ready,
  input logic [AW-1:0] rsp_addr,
  input logic [OW-1:0] rsp_order,
  input logic          rsp_fail,
  input logic          rsp_err,
  input logic          op_release,
  input logic          evt_split,
  input logic          evt_merge,
  input logic [OW-1:0] cur_ord,
  input logic [OW-1:0] tgt_ord
);
  // R9
  rsp_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_valid && !rsp_ready |=> rsp_valid && $stable(rsp_addr) && $stable(rsp_order)
                                 && $stable(rsp_fail) && $stable(rsp_err));

  // R9
  rsp_taken_chk: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_valid && rsp_ready |=> req_ready && !rsp_valid);

  // R3
  grant_align_chk: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_valid && !op_release && !rsp_fail |->
      rsp_order >= OW'(MIN_ORD) && rsp_order <= OW'(MAX_ORD) &&
      ((rsp_addr & ((AW'(1) << rsp_order) - AW'(1))) == '0));

  // R10
  fail_alloc_only_chk: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_valid && rsp_fail |-> !op_release && !rsp_err);

  // R10
  err_release_only_chk: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_valid && rsp_err |-> op_release);

  // R4
  split_above_target_chk: assert property (@(posedge clk) disable iff (!rst_n)
    evt_split |-> cur_ord > tgt_ord);

  // R6
  merge_below_top_chk: assert property (@(posedge clk) disable iff (!rst_n)
    evt_merge |-> cur_ord < OW'(MAX_ORD));

  // R6
  merge_climb_chk: assert property (@(posedge clk) disable iff (!rst_n)
    evt_merge |=> cur_ord == OW'($past(cur_ord) + 1'b1));
endmodule

bind buddy_alloc buddy_alloc_chk #(
  .MIN_ORD(MIN_ORD), .MAX_ORD(MAX_ORD), .AW(AW), .OW(OW)
) chk_i (
  .clk(clk), .rst_n(rst_n), .req_ready(req_ready),
  .rsp_valid(rsp_valid), .rsp_ready(rsp_ready), .rsp_addr(rsp_addr),
  .rsp_order(rsp_order), .rsp_fail(rsp_fail), .rsp_err(rsp_err),
  .op_release(op_release), .evt_split(evt_split), .evt_merge(evt_merge),
  .cur_ord(cur_ord), .tgt_ord(tgt_ord)
);

// File: tb/buddy_alloc_tb_top.sv
module buddy_alloc_tb_top;
  localparam int L = 5;
  localparam int U = 10;
  localparam int TOPB = 2;
  localparam int AW = 11;
  localparam int SW = 12;
  localparam int OW = 4;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic req_valid = 1'b0, req_release = 1'b0, rsp_ready = 1'b0;
  logic [SW-1:0] req_size = '0;
  logic [AW-1:0] req_addr = '0;
  logic [OW-1:0] req_order = '0;
  logic req_ready, busy, rsp_valid, rsp_fail, rsp_err;
  logic [AW-1:0] rsp_addr;
  logic [OW-1:0] rsp_order;

  always #10 clk = ~clk;

  buddy_alloc dut_i (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
    .req_release(req_release), .req_size(req_size), .req_addr(req_addr),
    .req_order(req_order), .busy(busy), .rsp_valid(rsp_valid),
    .rsp_ready(rsp_ready), .rsp_addr(rsp_addr), .rsp_order(rsp_order),
    .rsp_fail(rsp_fail), .rsp_err(rsp_err)
  );

  int nchk = 0, nfail = 0, nops = 0;
  bit mf [0:U-L][0:63];
  int held_a [0:255];
  int held_o [0:255];
  int nheld = 0;
  logic [15:0] lfsr = 16'hACE1;

  function automatic int blocks_at(int o);
    return TOPB * (1 << (U - o));
  endfunction

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    nchk++;
    if (!ok) begin
      nfail++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  task automatic step_lfsr();
    lfsr = {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
  endtask

  task automatic model_alloc(input int size, output bit f, output int a, output int k);
    int jj, ii;
    bit got;
    f = 0; a = 0; k = 0; got = 0; jj = 0; ii = 0;
    if (size > (1 << U)) begin f = 1; return; end
    k = L;
    while ((1 << k) < size) k++;
    for (int j = k; j <= U && !got; j++)
      for (int i = 0; i < blocks_at(j) && !got; i++)
        if (mf[j-L][i]) begin got = 1; jj = j; ii = i; end
    if (!got) begin f = 1; k = 0; return; end
    mf[jj-L][ii] = 0;
    while (jj > k) begin
      jj--;
      ii = ii * 2;
      mf[jj-L][ii+1] = 1;
    end
    a = ii * (1 << k);
  endtask

  task automatic model_release(input int addr, input int ord, output bit e);
    int i, j;
    e = 1;
    if (ord < L || ord > U) return;
    if (addr % (1 << ord) != 0) return;
    i = addr / (1 << ord);
    j = ord;
    if (mf[j-L][i]) return;
    e = 0;
    while (j < U && mf[j-L][i ^ 1]) begin
      mf[j-L][i ^ 1] = 0;
      i = i / 2;
      j++;
    end
    mf[j-L][i] = 1;
  endtask

  task automatic run_op(input bit rel, input int size, input int addr, input int ord,
                        input string tag);
    bit ef, ee;
    int ea, eo, n;
    if (rel) begin
      model_release(addr, ord, ee); ef = 0; ea = addr; eo = ord;
    end else begin
      model_alloc(size, ef, ea, eo); ee = 0;
    end
    @(negedge clk);
    req_valid = 1; req_release = rel; req_size = SW'(size);
    req_addr = AW'(addr); req_order = OW'(ord);
    @(negedge clk);
    req_valid = 0;
    chk(busy === 1'b1 && req_ready === 1'b0, "R9 busy after accept", int'(busy), 1);
    n = 0;
    while (rsp_valid !== 1'b1 && n < 100) begin @(negedge clk); n++; end
    chk(rsp_fail === ef, {tag, " fail flag"}, int'(rsp_fail), int'(ef));
    chk(rsp_err === ee, {tag, " err flag"}, int'(rsp_err), int'(ee));
    if (!ef && !ee) begin
      chk(int'(rsp_addr) == ea, {tag, " addr"}, int'(rsp_addr), ea);
      chk(int'(rsp_order) == eo, {tag, " order"}, int'(rsp_order), eo);
    end
    if (!rel && !ef) begin
      held_a[nheld] = ea; held_o[nheld] = eo; nheld++;
    end
    nops++;
    if (nops % 3 == 0) begin
      @(negedge clk);
      chk(rsp_valid === 1'b1 && int'(rsp_addr) == (ef ? 0 : ea) && rsp_err === ee,
          "R9 response held", int'(rsp_addr), ef ? 0 : ea);
    end
    rsp_ready = 1;
    @(negedge clk);
    rsp_ready = 0;
    chk(req_ready === 1'b1 && rsp_valid === 1'b0, "R9 ready after take", int'(req_ready), 1);
  endtask

  task automatic release_held(input int k, input string tag);
    int a, o;
    a = held_a[k]; o = held_o[k];
    nheld--;
    held_a[k] = held_a[nheld]; held_o[k] = held_o[nheld];
    run_op(1, 0, a, o, tag);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    nchk++; nfail++;
    $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
    $display("%0d/%0d checks passed", nchk - nfail, nchk);
    $finish;
  end

  initial begin
    for (int o = 0; o <= U - L; o++)
      for (int i = 0; i < 64; i++) mf[o][i] = 0;
    for (int i = 0; i < TOPB; i++) mf[U-L][i] = 1;

    repeat (3) @(negedge clk);
    // R1: outputs just after reset
    chk(req_ready === 1'b1 && busy === 1'b0 && rsp_valid === 1'b0,
        "R1 reset outputs", int'(req_ready), 1);
    rst_n = 1;

    // R1 R3: the two top blocks, then a fail because nothing is left (R5)
    run_op(0, 1024, 0, 0, "R1 top block 0");
    run_op(0, 1000, 0, 0, "R3 top block 1");
    run_op(0, 1, 0, 0, "R5 full region fail");
    release_held(0, "R6 release top");
    release_held(0, "R6 release top");

    // R2 R4: size 0 splits all the way down, then fits come from the split halves
    run_op(0, 0, 0, 0, "R2 size zero");
    run_op(0, 33, 0, 0, "R4 split remainder");
    run_op(0, 32, 0, 0, "R3 exact fit");
    run_op(0, 1025, 0, 0, "R2 oversize");
    run_op(0, 2047, 0, 0, "R2 oversize max");

    // R7: double release
    run_op(1, 0, held_a[2], held_o[2], "R7 first release");
    run_op(1, 0, held_a[2], held_o[2], "R7 double release");
    nheld = 2;
    // R8: bad orders and a misaligned address
    run_op(1, 0, 16, 5, "R8 misaligned");
    run_op(1, 0, 0, 4, "R8 order low");
    run_op(1, 0, 0, 11, "R8 order high");

    // Sweep of sizes until the region is full
    for (int s = 0; s <= 1100; s += 37) run_op(0, s, 0, 0, "R2 size sweep");
    while (nheld > 0) release_held(0, "R6 drain");
    run_op(0, 1024, 0, 0, "R6 rejoined top");
    run_op(0, 1024, 0, 0, "R6 rejoined top");
    run_op(0, 1024, 0, 0, "R5 fail when full");
    while (nheld > 0) release_held(nheld - 1, "R6 drain reverse");

    // Mixed operations driven by the LFSR
    for (int t = 0; t < 400; t++) begin
      step_lfsr();
      if (nheld > 0 && lfsr[1:0] == 2'd0)
        release_held(int'(lfsr[15:8]) % nheld, "R6 mixed release");
      else if (lfsr[2:0] == 3'd1)
        run_op(1, 0, int'(lfsr[10:0]), int'(lfsr[14:11]), "R8 mixed bad release");
      else
        run_op(0, int'(lfsr[15:4]) % 1200, 0, 0, "R4 mixed alloc");
    end
    while (nheld > 0) release_held(0, "R6 final drain");
    run_op(0, 1024, 0, 0, "R6 final top");
    run_op(0, 1024, 0, 0, "R6 final top");

    $display("%0d/%0d checks passed", nchk - nfail, nchk);
    $finish;
  end
endmodule